// File: doc/BRIEF.md
# Shared AES Byte Substitution Unit

This block is a purely combinational AES substitution box. A one-bit direction select makes it perform either the forward byte substitution used in encryption or the inverse substitution used in decryption. Both directions go through the same multiplicative inverter. That inverter works in a tower field, GF(((2^2)^2)^2), built from polynomial bases.

Each direction has its own linear front end and back end around the shared inverter. For encryption, the input byte is mapped into the tower field, inverted, and then passed through one merged matrix. That matrix combines the return map to the AES field with the affine step; the constant 0x63 is XORed in afterwards. For decryption, 0x63 is first XORed away. The result then goes through one merged matrix that combines the inverse affine step with the map into the tower field, is inverted, and is mapped back to the AES field.

All four 8x8 bit matrices are computed at elaboration. A constant function searches the tower field for a root of the AES field polynomial x^8+x^4+x^3+x+1, so no matrix is written out by hand. The unit is meant to sit inside a round datapath that registers it on both sides.

Top module: `sbox_shared`

## Requirements
- R1: With `inv_mode` = 0, `byte_out` equals the standard AES forward S-box of `byte_in` for all 256 input values.
- R2: With `inv_mode` = 1, `byte_out` equals the standard AES inverse S-box of `byte_in` for all 256 input values.
- R3: For every byte b, applying the unit with `inv_mode` = 1 to the forward result of b returns b.
- R4: Anchor values hold exactly. In forward mode: 0x00 -> 0x63, 0x01 -> 0x7C, 0x53 -> 0xED and 0xFF -> 0x16. In inverse mode: 0x63 -> 0x00, 0x7C -> 0x01, 0xED -> 0x53 and 0x16 -> 0xFF.
- R5: The shared tower-field inverter maps zero to zero. For every nonzero element, the product of the element and its inverter output is one; at both the 8-bit and the 4-bit level, one is the value 1 in the tower representation.
- R6: In neither mode is there a fixed point or an opposite fixed point: `byte_out` differs from both `byte_in` and its bitwise complement.
- R7: The output depends only on the present inputs. Changing `inv_mode` with `byte_in` held constant switches `byte_out` to the other direction's value with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_in | input | 8 | Byte to substitute |
| inv_mode | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| byte_out | output | 8 | Substituted byte |

## Verification
The embedded assertions check, on every input change, three things. Both inverter levels return a true multiplicative inverse (or zero for zero). The output never equals the input or its complement. The zero and 0x63 anchors hold in their respective modes. Only the bench can show that the merged matrices are the right ones. It does so by sweeping all 256 bytes in both modes against a reference built by brute-force inversion modulo the AES polynomial, by checking the decrypt-of-encrypt round trip, and by switching the mode with the byte held.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;

  // Field widths of the tower levels
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int PAIR_W = NIB_W / 2;
  localparam int MAT_W  = BYTE_W * BYTE_W;

  // Scale constant for the top tower level: lambda = w*z, chosen with trace one
  localparam logic [NIB_W-1:0] LAMBDA = 4'b1000;
  // Affine constant of the AES byte substitution
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;

  // GF(4) over w^2 = w + 1
  function automatic logic [1:0] gf4_mul(logic [1:0] a, logic [1:0] b);
    logic [1:0] r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  // Squaring in GF(4), which is also its inversion
  function automatic logic [1:0] gf4_sq(logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // Multiply by N = w
  function automatic logic [1:0] gf4_scale_n(logic [1:0] a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16) over z^2 = z + N
  function automatic logic [3:0] gf16_mul(logic [3:0] a, logic [3:0] b);
    logic [1:0] hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_scale_n(hh) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] gf16_sq(logic [3:0] a);
    logic [1:0] hs;
    hs = gf4_mul(a[3:2], a[3:2]);
    return {hs, gf4_scale_n(hs) ^ gf4_mul(a[1:0], a[1:0])};
  endfunction

  // GF(256) over y^2 = y + LAMBDA
  function automatic logic [7:0] gf256_mul(logic [7:0] a, logic [7:0] b);
    logic [3:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  // Matrices: column j (bits j*8 +: 8) is the image of basis bit j
  function automatic logic [7:0] mat_apply(logic [63:0] m, logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      if (v[j]) r = r ^ m[j*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  function automatic logic [63:0] mat_mul(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int j = 0; j < BYTE_W; j++) begin
      r[j*BYTE_W +: BYTE_W] = mat_apply(a, b[j*BYTE_W +: BYTE_W]);
    end
    return r;
  endfunction

  function automatic logic [7:0] mat_row(logic [63:0] m, int r);
    logic [7:0] row;
    for (int c = 0; c < BYTE_W; c++) begin
      row[c] = m[c*BYTE_W + r];
    end
    return row;
  endfunction

  // Tower element that is a root of x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] find_root();
    logic [7:0] root;
    logic       found;
    root  = '0;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      logic [7:0] e, e2, e3, e4, e8;
      if (!found) begin
        e  = c[7:0];
        e2 = gf256_mul(e, e);
        e3 = gf256_mul(e2, e);
        e4 = gf256_mul(e2, e2);
        e8 = gf256_mul(e4, e4);
        if ((e8 ^ e4 ^ e3 ^ e ^ 8'h01) == 8'h00) begin
          root  = e;
          found = 1'b1;
        end
      end
    end
    return root;
  endfunction

  // AES field -> tower field: bit j maps to root^j
  function automatic logic [63:0] iso_mat();
    logic [63:0] m;
    logic [7:0]  beta, pw;
    beta = find_root();
    pw   = 8'h01;
    for (int j = 0; j < BYTE_W; j++) begin
      m[j*BYTE_W +: BYTE_W] = pw;
      pw = gf256_mul(pw, beta);
    end
    return m;
  endfunction

  // Inverse of a nonsingular matrix, found from the images of all bytes
  function automatic logic [63:0] mat_inverse(logic [63:0] m);
    logic [63:0] r;
    r = '0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = mat_apply(m, v[7:0]);
      for (int k = 0; k < BYTE_W; k++) begin
        if (w == (8'h01 << k)) r[k*BYTE_W +: BYTE_W] = v[7:0];
      end
    end
    return r;
  endfunction

  // Affine step: out bit i collects in bits i, i+4, i+5, i+6, i+7 (mod 8)
  function automatic logic [63:0] affine_mat();
    logic [63:0] m;
    for (int j = 0; j < BYTE_W; j++) begin
      for (int i = 0; i < BYTE_W; i++) begin
        int d;
        d = (j - i) & 7;
        m[j*BYTE_W + i] = (d == 0) || (d >= 4);
      end
    end
    return m;
  endfunction

  // Inverse affine step: out bit i collects in bits i+2, i+5, i+7 (mod 8)
  function automatic logic [63:0] inv_affine_mat();
    logic [63:0] m;
    for (int j = 0; j < BYTE_W; j++) begin
      for (int i = 0; i < BYTE_W; i++) begin
        int d;
        d = (j - i) & 7;
        m[j*BYTE_W + i] = (d == 2) || (d == 5) || (d == 7);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/sbox_lin_map.sv
module sbox_lin_map
  import sbox_tower_pkg::*;
#(
  parameter logic [63:0] MAT = 64'h8040_2010_0804_0201
) (
  input  logic [7:0] v_in,
  output logic [7:0] v_out
);

  // One XOR tree per output bit over the taps selected by that matrix row
  for (genvar r = 0; r < BYTE_W; r++) begin : g_row
    localparam logic [7:0] ROW = mat_row(MAT, r);
    assign v_out[r] = ^(ROW & v_in);
  end

endmodule

// File: rtl/sbox_gf16_inv.sv
module sbox_gf16_inv
  import sbox_tower_pkg::*;
(
  input  logic [3:0] a_in,
  output logic [3:0] a_inv
);

  logic [1:0] hi, lo;
  logic [1:0] norm, norm_inv;

  assign hi = a_in[3:2];
  assign lo = a_in[1:0];

  // Norm-like term; GF(4) inversion is a bit swap-and-add
  assign norm     = gf4_scale_n(gf4_sq(hi)) ^ gf4_mul(hi, lo) ^ gf4_sq(lo);
  assign norm_inv = gf4_sq(norm);
  assign a_inv    = {gf4_mul(norm_inv, hi), gf4_mul(norm_inv, hi ^ lo)};

  always_comb begin
    if (a_in != 4'h0) begin
      AST_NIB_INV_PRODUCT: assert (gf16_mul(a_in, a_inv) == 4'h1) // R5
        else $error("nibble inverter product is not one");
    end else begin
      AST_NIB_INV_ZERO: assert (a_inv == 4'h0) // R5
        else $error("nibble inverter maps zero to nonzero");
    end
  end

endmodule

// File: rtl/sbox_gf256_inv.sv
module sbox_gf256_inv
  import sbox_tower_pkg::*;
(
  input  logic [7:0] x_in,
  output logic [7:0] x_inv
);

  logic [3:0] hi, lo;
  logic [3:0] theta, theta_inv;

  assign hi = x_in[7:4];
  assign lo = x_in[3:0];

  assign theta = gf16_mul(gf16_sq(hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);

  sbox_gf16_inv u_nib_inv (
    .a_in  (theta),
    .a_inv (theta_inv)
  );

  assign x_inv = {gf16_mul(theta_inv, hi), gf16_mul(theta_inv, hi ^ lo)};

  always_comb begin
    if (x_in != 8'h00) begin
      AST_BYTE_INV_PRODUCT: assert (gf256_mul(x_in, x_inv) == 8'h01) // R5
        else $error("byte inverter product is not one");
    end else begin
      AST_BYTE_INV_ZERO: assert (x_inv == 8'h00) // R5
        else $error("byte inverter maps zero to nonzero");
    end
  end

endmodule

// File: rtl/sbox_shared.sv
module sbox_shared
  import sbox_tower_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic       inv_mode,
  output logic [7:0] byte_out
);

  // Linear maps derived at elaboration
  localparam logic [63:0] TO_TOWER   = iso_mat();
  localparam logic [63:0] FROM_TOWER = mat_inverse(TO_TOWER);
  localparam logic [63:0] FWD_OUT    = mat_mul(affine_mat(), FROM_TOWER);
  localparam logic [63:0] INV_IN     = mat_mul(TO_TOWER, inv_affine_mat());

  logic [7:0] fwd_in_t, inv_in_t, field_in;
  logic [7:0] field_inv, fwd_out_m, inv_out_m;

  // Input side: forward maps the byte straight in; inverse strips 0x63 first
  sbox_lin_map #(.MAT(TO_TOWER)) u_fwd_in (
    .v_in  (byte_in),
    .v_out (fwd_in_t)
  );

  sbox_lin_map #(.MAT(INV_IN)) u_inv_in (
    .v_in  (byte_in ^ AFF_C),
    .v_out (inv_in_t)
  );

  assign field_in = inv_mode ? inv_in_t : fwd_in_t;

  // Single inverter shared by both directions
  sbox_gf256_inv u_inv (
    .x_in  (field_in),
    .x_inv (field_inv)
  );

  // Output side: merged return map plus affine, or plain return map
  sbox_lin_map #(.MAT(FWD_OUT)) u_fwd_out (
    .v_in  (field_inv),
    .v_out (fwd_out_m)
  );

  sbox_lin_map #(.MAT(FROM_TOWER)) u_inv_out (
    .v_in  (field_inv),
    .v_out (inv_out_m)
  );

  assign byte_out = inv_mode ? inv_out_m : (fwd_out_m ^ AFF_C);

  always_comb begin
    AST_NO_FIXED_POINT: assert ((byte_out != byte_in) && (byte_out != ~byte_in)) // R6
      else $error("substitution produced a fixed or opposite fixed point");
    if (!inv_mode && byte_in == 8'h00) begin
      AST_FWD_ZERO_ANCHOR: assert (byte_out == 8'h63) // R4
        else $error("forward zero anchor wrong");
    end
    if (inv_mode && byte_in == 8'h63) begin
      AST_INV_ZERO_ANCHOR: assert (byte_out == 8'h00) // R4
        else $error("inverse zero anchor wrong");
    end
  end

endmodule

// File: tb/tb_sbox_shared.sv
module tb_sbox_shared;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk;
  logic [7:0] byte_in;
  logic       inv_mode;
  logic [7:0] byte_out;

  int  checks = 0;
  int  errors = 0;
  logic done = 1'b0;

  logic [7:0] ref_fwd [256];
  logic [7:0] ref_inv [256];

  // {mode, input, expected}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7C}, {1'b0, 8'h53, 8'hED},
    {1'b0, 8'hFF, 8'h16}, {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7C, 8'h01},
    {1'b1, 8'hED, 8'h53}, {1'b1, 8'h16, 8'hFF}
  };

  sbox_shared dut (
    .byte_in  (byte_in),
    .inv_mode (inv_mode),
    .byte_out (byte_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_recip(logic [7:0] a);
    logic [7:0] r;
    r = '0;
    for (int c = 1; c < 256; c++) begin
      if (ref_mul(a, c[7:0]) == 8'h01) r = c[7:0];
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_affine(logic [7:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(logic mode, logic [7:0] b);
    @(negedge clk);
    inv_mode = mode;
    byte_in  = b;
    #1;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    inv_mode = 1'b0;
    byte_in  = 8'h00;
    for (int v = 0; v < 256; v++) begin
      ref_fwd[v] = ref_affine(ref_recip(v[7:0]));
    end
    for (int v = 0; v < 256; v++) begin
      ref_inv[ref_fwd[v]] = v[7:0];
    end

    // Initial input state: forward of zero (R4, R5)
    #1;
    check("R4 initial forward zero", byte_out, 8'h63);

    // Anchor table (R4)
    for (int k = 0; k < 8; k++) begin
      drive(VEC[k][16], VEC[k][15:8]);
      check("R4 anchor", byte_out, VEC[k][7:0]);
    end

    // Zero handling of the shared inverter in both directions (R5)
    drive(1'b0, 8'h00);
    check("R5 inverter zero forward", byte_out, 8'h63);
    drive(1'b1, 8'h63);
    check("R5 inverter zero inverse", byte_out, 8'h00);

    // Full forward sweep (R1) with fixed point test (R6)
    for (int v = 0; v < 256; v++) begin
      drive(1'b0, v[7:0]);
      check("R1 forward", byte_out, ref_fwd[v]);
      check("R6 forward no fixed point",
            {7'd0, (byte_out == v[7:0]) || (byte_out == ~v[7:0])}, 8'h00);
    end

    // Full inverse sweep (R2) with fixed point test (R6)
    for (int v = 0; v < 256; v++) begin
      drive(1'b1, v[7:0]);
      check("R2 inverse", byte_out, ref_inv[v]);
      check("R6 inverse no fixed point",
            {7'd0, (byte_out == v[7:0]) || (byte_out == ~v[7:0])}, 8'h00);
    end

    // Round trip through the device in both directions (R3)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] fwd_val;
      drive(1'b0, v[7:0]);
      fwd_val = byte_out;
      drive(1'b1, fwd_val);
      check("R3 round trip", byte_out, v[7:0]);
    end

    // Mode switch with the byte held, no clock edge between (R7)
    drive(1'b0, 8'h53);
    check("R7 held byte forward", byte_out, ref_fwd[8'h53]);
    inv_mode = 1'b1;
    #1;
    check("R7 held byte inverse", byte_out, ref_inv[8'h53]);
    inv_mode = 1'b0;
    #1;
    check("R7 held byte forward again", byte_out, ref_fwd[8'h53]);

    done = 1'b1;
    report();
  end

endmodule